// File: doc/BRIEF.md
# Packet-Filter VM Integer ALU

This block is the integer execution unit of a 64-bit register virtual machine used for packet filtering. Each cycle it takes one arithmetic or byte-order instruction, given as an 8-bit opcode, a 16-bit offset field, a 32-bit immediate and the two 64-bit operand values (destination and source). It returns the new destination value one clock later, together with flags that mark an illegal encoding or an operation this unit does not implement.

Both arithmetic classes are handled. The narrow class works on the low 32 bits and always clears the upper half of its result. The wide class works on all 64 bits. The operation set covers add, subtract, multiply, the bitwise ops, three kinds of shift, negate, plain and sign-extending moves, and conversions to little-endian or big-endian order on a little-endian host. Divide and modulo are not implemented: they raise a separate flag so that another unit can take the instruction over. Register-file storage, memory access and branches belong to other blocks.

Top module: `pf_alu`

## Requirements
- R1: Opcode layout: bits 2:0 are the class (4 = narrow 32-bit, 7 = wide 64-bit), bit 3 is the source select (0 = sign-extended immediate, 1 = source register), and bits 7:4 are the operation code. Results are registered, so they appear on the clock edge after their inputs are applied. While reset is held, all outputs read zero.
- R2: The operation codes are add 0x0, subtract 0x1, multiply 0x2, or 0x4, and 0x5, xor 0xa and move 0xb. Each computes dst op src with wraparound, and move returns src.
- R3: A narrow-class operation uses only the low 32 bits of its operands, and bits 63:32 of its result are zero. Byte-order conversion of width 64 is the one exception (see R8).
- R4: An immediate source is sign-extended from 32 to 64 bits in the wide class. In the narrow class it is used as a 32-bit value.
- R5: Left shift 0x6, logical right shift 0x7 and arithmetic right shift 0xc take their shift count from src masked with 0x3F (wide) or 0x1F (narrow). The arithmetic shift fills with the sign bit of the operand width.
- R6: Negate 0x8 returns the two's complement of dst. It is illegal when the source bit is 1.
- R7: A move with offset 8, 16 or 32 sign-extends that many low bits of the register source. It is illegal with an immediate source, with any other nonzero offset, and with offset 32 in the narrow class.
- R8: Byte-order code 0xd operates on dst only and takes its width (16, 32 or 64) from the immediate. A little-endian target (narrow class, source bit 0) keeps the low field and zero-extends it. A big-endian target (narrow class, source bit 1) and the wide-class swap both reverse the bytes of the low field and zero-extend the result.
- R9: A byte-order op is illegal when the immediate is not 16, 32 or 64, or when it is wide-class with the source bit set.
- R10: The illegal flag is also raised for a class other than 4 or 7, for operation codes 0xe and 0xf, and for a nonzero offset on any supported operation other than move.
- R11: Operation codes 0x3 (divide) and 0x9 (modulo) in class 4 or 7 raise the unsupported flag whatever the offset, never raise the illegal flag, and return dst unchanged.
- R12: When the illegal flag is raised, the result is dst unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 8 | Instruction opcode |
| offset_i | input | 16 | Offset field (selects the sign-extending move width) |
| imm_i | input | 32 | Immediate field |
| dst_i | input | 64 | Destination operand value |
| src_i | input | 64 | Source register operand value |
| result_o | output | 64 | New destination value, registered |
| illegal_o | output | 1 | Illegal encoding, registered |
| unsupported_o | output | 1 | Divide or modulo requested, registered |

## Verification
All three outputs come from one register stage, so each result is due on the first rising edge after its inputs are applied. The bench changes the inputs on a falling edge, waits for the next rising edge, and reads the outputs shortly after it. It then compares them with a behavioural model evaluated on the same inputs, so each check covers exactly one instruction. The directed vectors cover the masking limits of each shift, every width of sign extension and byte reversal, and each illegal combination. A long run of random encodings follows them.

// File: rtl/pf_alu_pkg.sv
package pf_alu_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned HLEN = XLEN / 2;
  localparam int unsigned NBYTES = XLEN / 8;

  localparam logic [2:0] CLS_NARROW = 3'h4;
  localparam logic [2:0] CLS_WIDE   = 3'h7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_ARSH = 4'hc,
    OP_END  = 4'hd,
    OP_RSVE = 4'he,
    OP_RSVF = 4'hf
  } op_e;

  typedef enum logic [1:0] {
    SX_NONE = 2'd0,
    SX_B8   = 2'd1,
    SX_B16  = 2'd2,
    SX_B32  = 2'd3
  } sx_e;

  typedef enum logic [1:0] {
    BW_16 = 2'd0,
    BW_32 = 2'd1,
    BW_64 = 2'd2
  } bw_e;
endpackage

// File: rtl/pf_alu_decode.sv
module pf_alu_decode
  import pf_alu_pkg::*;
(
  input  logic [7:0]  opcode_i,
  input  logic [15:0] offset_i,
  input  logic [31:0] imm_i,
  output logic        wide_o,
  output logic        use_reg_o,
  output op_e         op_o,
  output sx_e         sx_o,
  output bw_e         bw_o,
  output logic        swap_o,
  output logic        illegal_o,
  output logic        unsup_o
);
  logic cls_ok, off_bad, neg_bad, mov_bad, end_bad, code_bad, bw_ok;

  assign op_o      = op_e'(opcode_i[7:4]);
  assign use_reg_o = opcode_i[3];
  assign wide_o    = (opcode_i[2:0] == CLS_WIDE);
  assign cls_ok    = wide_o || (opcode_i[2:0] == CLS_NARROW);

  always_comb begin
    sx_o = SX_NONE;
    unique case (offset_i)
      16'd8:   sx_o = SX_B8;
      16'd16:  sx_o = SX_B16;
      16'd32:  sx_o = SX_B32;
      default: sx_o = SX_NONE;
    endcase
  end

  always_comb begin
    bw_o  = BW_16;
    bw_ok = 1'b1;
    unique case (imm_i)
      32'd16:  bw_o = BW_16;
      32'd32:  bw_o = BW_32;
      32'd64:  bw_o = BW_64;
      default: bw_ok = 1'b0;
    endcase
  end

  // wide class always swaps; narrow swaps only for big-endian target
  assign swap_o   = wide_o || use_reg_o;

  assign unsup_o  = cls_ok && (op_o == OP_DIV || op_o == OP_MOD);
  assign off_bad  = (op_o != OP_MOV) && (offset_i != '0);
  assign neg_bad  = (op_o == OP_NEG) && use_reg_o;
  assign mov_bad  = (op_o == OP_MOV) && (offset_i != '0) &&
                    (!use_reg_o || sx_o == SX_NONE || (sx_o == SX_B32 && !wide_o));
  assign end_bad  = (op_o == OP_END) && (!bw_ok || (wide_o && use_reg_o));
  assign code_bad = (op_o == OP_RSVE) || (op_o == OP_RSVF);

  assign illegal_o = !cls_ok ||
                     (!unsup_o && (off_bad || neg_bad || mov_bad || end_bad || code_bad));
endmodule

// File: rtl/pf_alu_core.sv
module pf_alu_core
  import pf_alu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  op_e          op_i,
  input  sx_e          sx_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned SH = $clog2(W);

  logic [SH-1:0] sh;
  logic [W-1:0]  mov_val;

  assign sh = b_i[SH-1:0];

  always_comb begin
    unique case (sx_i)
      SX_B8:   mov_val = W'($signed(b_i[7:0]));
      SX_B16:  mov_val = W'($signed(b_i[15:0]));
      SX_B32:  mov_val = W'($signed(b_i[31:0]));
      default: mov_val = b_i;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_LSH:  res_o = a_i << sh;
      OP_RSH:  res_o = a_i >> sh;
      OP_ARSH: res_o = W'($signed(a_i) >>> sh);
      OP_NEG:  res_o = '0 - a_i;
      OP_MOV:  res_o = mov_val;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/pf_alu_bswap.sv
module pf_alu_bswap
  import pf_alu_pkg::*;
(
  input  logic [XLEN-1:0] val_i,
  input  bw_e             bw_i,
  input  logic            swap_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] rev64;
  logic [31:0]     rev32;
  logic [15:0]     rev16;

  for (genvar g = 0; g < NBYTES; g++) begin : g_rev64
    assign rev64[8*g +: 8] = val_i[8*(NBYTES-1-g) +: 8];
  end
  for (genvar g = 0; g < 4; g++) begin : g_rev32
    assign rev32[8*g +: 8] = val_i[8*(3-g) +: 8];
  end
  for (genvar g = 0; g < 2; g++) begin : g_rev16
    assign rev16[8*g +: 8] = val_i[8*(1-g) +: 8];
  end

  always_comb begin
    unique case (bw_i)
      BW_16:   res_o = swap_i ? XLEN'(rev16) : XLEN'(val_i[15:0]);
      BW_32:   res_o = swap_i ? XLEN'(rev32) : XLEN'(val_i[31:0]);
      default: res_o = swap_i ? rev64 : val_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({bw_i, res_o}) && bw_i == BW_16)
      a_r8_field16_zext: assert (res_o[XLEN-1:16] == '0);
  end
endmodule

// File: rtl/pf_alu.sv
module pf_alu
  import pf_alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      opcode_i,
  input  logic [15:0]     offset_i,
  input  logic [31:0]     imm_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o,
  output logic            unsupported_o
);
  logic            wide, use_reg, swap, illegal, unsup;
  op_e             op;
  sx_e             sx;
  bw_e             bw;
  logic [XLEN-1:0] b_op, res_wide, res_end, res_d;
  logic [HLEN-1:0] res_narrow;
  logic            q_narrow;

  pf_alu_decode u_dec (
    .opcode_i  (opcode_i),
    .offset_i  (offset_i),
    .imm_i     (imm_i),
    .wide_o    (wide),
    .use_reg_o (use_reg),
    .op_o      (op),
    .sx_o      (sx),
    .bw_o      (bw),
    .swap_o    (swap),
    .illegal_o (illegal),
    .unsup_o   (unsup)
  );

  assign b_op = use_reg ? src_i : XLEN'($signed(imm_i));

  pf_alu_core #(.W(XLEN)) u_core_wide (
    .op_i  (op),
    .sx_i  (sx),
    .a_i   (dst_i),
    .b_i   (b_op),
    .res_o (res_wide)
  );

  pf_alu_core #(.W(HLEN)) u_core_narrow (
    .op_i  (op),
    .sx_i  (sx),
    .a_i   (dst_i[HLEN-1:0]),
    .b_i   (b_op[HLEN-1:0]),
    .res_o (res_narrow)
  );

  pf_alu_bswap u_bswap (
    .val_i  (dst_i),
    .bw_i   (bw),
    .swap_i (swap),
    .res_o  (res_end)
  );

  always_comb begin
    if (illegal || unsup) res_d = dst_i;
    else if (op == OP_END) res_d = res_end;
    else if (wide)         res_d = res_wide;
    else                   res_d = XLEN'(res_narrow);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o      <= '0;
      illegal_o     <= 1'b0;
      unsupported_o <= 1'b0;
      q_narrow      <= 1'b0;
    end else begin
      result_o      <= res_d;
      illegal_o     <= illegal;
      unsupported_o <= unsup;
      q_narrow      <= (opcode_i[2:0] == CLS_NARROW) && (opcode_i[7:4] != OP_END);
    end
  end

  a_r12_illegal_keeps_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == $past(dst_i));

  a_r11_unsup_keeps_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |-> result_o == $past(dst_i));

  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({illegal_o, unsupported_o}));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_narrow && !illegal_o && !unsupported_o) |-> result_o[XLEN-1:HLEN] == '0);
endmodule

// File: tb/sim_pf_alu.sv
module sim_pf_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opc = '0;
  logic [15:0] off = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst = '0, src = '0;
  logic [63:0] res;
  logic        ill, uns;
  int          checks = 0, failures = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  pf_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opc), .offset_i(off), .imm_i(imm),
    .dst_i(dst), .src_i(src), .result_o(res), .illegal_o(ill), .unsupported_o(uns)
  );

  function automatic logic [63:0] byte_rev(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
    return r;
  endfunction

  task automatic model(input logic [7:0] o, input logic [15:0] of, input logic [31:0] im,
                       input logic [63:0] d, input logic [63:0] s,
                       output logic [63:0] r, output bit il, output bit un);
    logic [2:0]  cls = o[2:0];
    bit          x = o[3];
    int          code = int'(o[7:4]);
    bit          w = (cls == 3'd7);
    logic [63:0] a, b, t;
    int          sh, n;
    logic signed [31:0] s32;
    il = 0; un = 0; r = d; t = '0;
    if (cls != 3'd4 && cls != 3'd7) begin il = 1; return; end
    if (code == 3 || code == 9) begin un = 1; return; end
    a = w ? d : {32'b0, d[31:0]};
    if (x) b = w ? s : {32'b0, s[31:0]};
    else   b = w ? {{32{im[31]}}, im} : {32'b0, im};
    sh = w ? int'(b & 64'h3f) : int'(b & 64'h1f);
    if (code != 11 && of != 0) il = 1;
    case (code)
      0: t = a + b;
      1: t = a - b;
      2: t = a * b;
      4: t = a | b;
      5: t = a & b;
      6: t = a << sh;
      7: t = a >> sh;
      8: begin t = -a; if (x) il = 1; end
      10: t = a ^ b;
      11: begin
        if (of == 0) t = b;
        else if (!x) il = 1;
        else if (of == 8)  t = {{56{s[7]}}, s[7:0]};
        else if (of == 16) t = {{48{s[15]}}, s[15:0]};
        else if (of == 32 && w) t = {{32{s[31]}}, s[31:0]};
        else il = 1;
      end
      12: begin
        if (w) t = $signed(a) >>> sh;
        else begin s32 = a[31:0]; s32 = s32 >>> sh; t = {32'b0, s32}; end
      end
      13: begin
        if (w && x) il = 1;
        if (im == 16 || im == 32 || im == 64) begin
          n = int'(im) / 8;
          if (w || x) t = byte_rev(d, n);
          else t = (n == 8) ? d : (d & ((64'd1 << (8*n)) - 1));
        end else il = 1;
        if (!il) r = t;
        return;
      end
      default: il = 1;
    endcase
    if (!il) r = w ? t : {32'b0, t[31:0]};
  endtask

  task automatic run(input string tag, input logic [7:0] o, input logic [15:0] of,
                     input logic [31:0] im, input logic [63:0] d, input logic [63:0] s);
    logic [63:0] er;
    bit eil, eun;
    @(negedge clk);
    opc = o; off = of; imm = im; dst = d; src = s;
    model(o, of, im, d, s, er, eil, eun);
    @(posedge clk);
    #2;
    checks++;
    if (res !== er || ill !== eil || uns !== eun) begin
      failures++;
      $display("FAIL %s op=%h off=%0d imm=%h: got res=%h ill=%b uns=%b exp res=%h ill=%b uns=%b",
               tag, o, of, im, res, ill, uns, er, eil, eun);
    end
  endtask

  function automatic logic [7:0] enc(input int code, input bit x, input logic [2:0] cls);
    return {code[3:0], x, cls};
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got hang exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] D;
    D = 64'h1122334455667788;
    repeat (3) @(posedge clk);
    #2;
    checks++;  // R1 reset state
    if (res !== '0 || ill !== 1'b0 || uns !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got res=%h ill=%b uns=%b exp 0 0 0", res, ill, uns);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 / R2: wide arithmetic and bitwise
    run("R2 add wrap",   enc(0, 1, 7), 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    run("R2 sub",        enc(1, 1, 7), 0, 0, 64'd3, 64'd5);
    run("R2 mul",        enc(2, 1, 7), 0, 0, 64'h1_0000_0001, 64'h1_0000_0003);
    run("R2 or",         enc(4, 1, 7), 0, 0, 64'hF0F0, 64'h0F0F_0000_0000_0000);
    run("R2 and",        enc(5, 1, 7), 0, 0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0);
    run("R2 xor",        enc(10, 1, 7), 0, 0, D, 64'hFFFF_0000_FFFF_0000);
    run("R2 mov reg",    enc(11, 1, 7), 0, 0, D, 64'hDEAD_BEEF_0000_0001);
    // R3: narrow class
    run("R3 add32",      enc(0, 1, 4), 0, 0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0002);
    run("R3 mul32",      enc(2, 1, 4), 0, 0, 64'h0000_0001_0001_0000, 64'h0000_0007_0001_0000);
    run("R3 mov32",      enc(11, 1, 4), 0, 0, D, 64'hFFFF_FFFF_8000_0000);
    // R4: immediate extension
    run("R4 add64 imm",  enc(0, 0, 7), 0, 32'hFFFF_FFFF, 64'd5, '0);
    run("R4 add32 imm",  enc(0, 0, 4), 0, 32'hFFFF_FFFF, 64'd5, '0);
    run("R4 mov64 imm",  enc(11, 0, 7), 0, 32'h8000_0000, D, '0);
    // R5: shifts
    run("R5 lsh64 mask", enc(6, 1, 7), 0, 0, 64'h8000_0000_0000_0001, 64'd65);
    run("R5 lsh32 mask", enc(6, 1, 4), 0, 0, 64'h1234_5678_8000_0001, 64'd33);
    run("R5 rsh64 63",   enc(7, 0, 7), 0, 32'd63, 64'h8000_0000_0000_0000, '0);
    run("R5 arsh64",     enc(12, 1, 7), 0, 0, 64'h8000_0000_0000_0000, 64'd4);
    run("R5 arsh32",     enc(12, 0, 4), 0, 32'd4, 64'h0000_0000_8000_0000, '0);
    run("R5 arsh32 m",   enc(12, 0, 4), 0, 32'd36, 64'hFFFF_FFFF_7000_0000, '0);
    // R6: negate
    run("R6 neg64",      enc(8, 0, 7), 0, 0, 64'd1, '0);
    run("R6 neg32",      enc(8, 0, 4), 0, 0, 64'd1, '0);
    run("R6 neg reg ill",enc(8, 1, 7), 0, 0, D, 64'd9);
    // R7: sign-extending move
    run("R7 sx8",        enc(11, 1, 7), 8, 0, D, 64'h80);
    run("R7 sx16",       enc(11, 1, 7), 16, 0, D, 64'h0000_0000_0001_8001);
    run("R7 sx32",       enc(11, 1, 7), 32, 0, D, 64'h0000_0001_8000_0000);
    run("R7 sx16 n",     enc(11, 1, 4), 16, 0, D, 64'hFFFF_0000_0000_9000);
    run("R7 sx32 n ill", enc(11, 1, 4), 32, 0, D, 64'h8000_0000);
    run("R7 sx imm ill", enc(11, 0, 7), 8, 32'h80, D, '0);
    run("R7 off5 ill",   enc(11, 1, 7), 5, 0, D, 64'h80);
    // R8: byte order
    run("R8 le16",       enc(13, 0, 4), 0, 32'd16, D, '0);
    run("R8 le32",       enc(13, 0, 4), 0, 32'd32, D, '0);
    run("R8 le64",       enc(13, 0, 4), 0, 32'd64, D, '0);
    run("R8 be32",       enc(13, 1, 4), 0, 32'd32, D, '0);
    run("R8 be64",       enc(13, 1, 4), 0, 32'd64, D, '0);
    run("R8 swap16",     enc(13, 0, 7), 0, 32'd16, D, '0);
    run("R8 swap64",     enc(13, 0, 7), 0, 32'd64, D, '0);
    // R9: byte-order illegal
    run("R9 width8 ill", enc(13, 0, 4), 0, 32'd8, D, '0);
    run("R9 wide src",   enc(13, 1, 7), 0, 32'd32, D, '0);
    // R10 / R12: other illegal encodings keep dst
    run("R10 class0",    enc(0, 1, 0), 0, 0, D, 64'd1);
    run("R10 code e",    enc(14, 1, 7), 0, 0, D, 64'd1);
    run("R10 add off",   enc(0, 1, 7), 1, 0, D, 64'd1);
    run("R12 end off",   enc(13, 0, 4), 4, 32'd16, D, '0);
    // R11: divide / modulo
    run("R11 div",       enc(3, 1, 7), 0, 0, D, 64'd3);
    run("R11 smod",      enc(9, 0, 4), 1, 32'd3, D, '0);
    run("R11 div cls6",  enc(3, 1, 6), 0, 0, D, 64'd3);

    // random sweep across R2..R12
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  o;
      logic [15:0] of;
      logic [31:0] im;
      int          sel;
      o = 8'($urandom);
      if ($urandom_range(0, 7) != 0) o[2:0] = ($urandom_range(0, 1) != 0) ? 3'd7 : 3'd4;
      sel = $urandom_range(0, 9);
      of = (sel < 6) ? 16'd0 : (sel == 6) ? 16'd8 : (sel == 7) ? 16'd16 :
           (sel == 8) ? 16'd32 : 16'($urandom);
      sel = $urandom_range(0, 4);
      im = (sel == 0) ? 32'd16 : (sel == 1) ? 32'd32 : (sel == 2) ? 32'd64 : $urandom;
      run("R2-R12 random", o, of, im, {$urandom, $urandom}, {$urandom, $urandom});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule